// File: doc/BRIEF.md
# TLB Replacement Victim Selector

This block decides which translation buffer entry gets overwritten when a new translation has to be installed. It watches every entry that the lookup path reports as used, and on each allocate request it names one victim entry. A single policy input, which may change from cycle to cycle, chooses between two schemes. The first is an approximate least-recently-used scheme that keeps one "recently used" bit per entry. The second is a cheap rotating scheme whose only promise is that it never picks the entry used last.

The victim is registered and is presented one cycle after the request. A small output state machine has two states. `OUT_IDLE` means no victim is on the output. `OUT_PRESENT` means `victim_idx` is valid. Every cycle with `alloc_req` high moves the machine to `OUT_PRESENT`, and every cycle without it moves the machine to `OUT_IDLE`. The allocated entry is itself treated as used, so back-to-back requests walk through the entries.

Top module: `tlb_victim_sel`

## Requirements
- R1: `policy_sel` = 0 selects the used-bit scheme and `policy_sel` = 1 selects the rotating scheme. The value sampled in the cycle of the allocate request decides that request.
- R2: `victim_vld` is high exactly in the cycle that follows a cycle with `alloc_req` high, and `victim_idx` carries the victim in that cycle.
- R3: Under the used-bit scheme the victim is the lowest-numbered entry whose used bit is clear.
- R4: When setting an entry's used bit would make every bit set, all bits are cleared except that entry's, so the mask is never all ones.
- R5: Under the rotating scheme the victim is the pointer value. If the pointer equals the last-used index, the victim is the next index (wrapping from N-1 to 0), so the victim never equals the last-used entry.
- R6: On every allocation, under either scheme, the pointer moves to one past the rotating candidate, wrapping from N-1 to 0.
- R7: An allocated entry is marked used (R4 folding applies) and becomes the last-used entry.
- R8: When `use_vld` and `alloc_req` are high in the same cycle, the use is applied first: it updates the mask and the last-used index that this allocation sees.
- R9: Reset (active-low `rst_n`) clears the mask, sets the last-used index and the pointer to 0, and holds `victim_vld` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_vld | input | 1 | An entry was used (hit) this cycle |
| use_idx | input | IDX_W | Index of the used entry |
| alloc_req | input | 1 | Request for a victim entry |
| policy_sel | input | 1 | 0 = used-bit scheme, 1 = rotating scheme |
| victim_vld | output | 1 | Victim index valid (one cycle after request) |
| victim_idx | output | IDX_W | Entry chosen for replacement |

## Verification
The hardest situations to reach are a collision of the rotating pointer with the last-used index right at the wrap point, and a mask fold triggered by a use rather than an allocation. Neither shows on the ports until a later allocation reveals the state. The stimulus therefore uses a four-entry instance and drives hand-planned sequences. These sequences include simultaneous use-and-allocate cycles that steer the last-used index onto the pointer at N-1, and they fill the mask through both paths. The scheme is also switched mid-stream, so that both schemes start from state the other one left behind.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;

    typedef enum logic {
        POL_LRU = 1'b0,
        POL_NLU = 1'b1
    } policy_e;

    typedef enum logic {
        OUT_IDLE    = 1'b0,
        OUT_PRESENT = 1'b1
    } out_state_e;

endpackage

// File: rtl/tlbv_mark.sv
// Sets one used bit in a mask; if that would fill the mask, keeps only that bit.
module tlbv_mark #(
    parameter int N_ENTRIES = 16,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0] mask_i,
    input  logic                 set_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic [N_ENTRIES-1:0] mask_o
);
    logic [N_ENTRIES-1:0] onehot;
    logic [N_ENTRIES-1:0] merged;

    always_comb begin
        onehot = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (IDX_W'(i) == idx_i) onehot[i] = 1'b1;
        end
        merged = mask_i | onehot;
        if (!set_i)        mask_o = mask_i;
        else if (&merged)  mask_o = onehot;
        else               mask_o = merged;
    end
endmodule

// File: rtl/tlbv_first_clear.sv
// Priority encoder: lowest index whose bit is clear.
module tlbv_first_clear #(
    parameter int N_ENTRIES = 16,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0] mask_i,
    output logic [IDX_W-1:0]     idx_o,
    output logic                 found_o
);
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!mask_i[i]) begin
                idx_o   = IDX_W'(i);
                found_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlbv_rotor.sv
// Rotating candidate pointer that steps over the last-used index.
module tlbv_rotor #(
    parameter int N_ENTRIES = 16,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [IDX_W-1:0] last_i,
    output logic [IDX_W-1:0] cand_o
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N_ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] v);
        return (v == TOP_IDX) ? '0 : v + 1'b1;
    endfunction

    always_comb begin
        cand_o = (ptr_q == last_i) ? step(ptr_q) : ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ptr_q <= '0;
        else if (adv_i) ptr_q <= step(cand_o);
    end

    // R5: the candidate never lands on the last-used entry
    p_cand_not_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cand_o != last_i);

    // R6: pointer moves only on an allocation
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(ptr_q));
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
    import tlbv_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_vld,
    input  logic [IDX_W-1:0] use_idx,
    input  logic             alloc_req,
    input  logic             policy_sel,
    output logic             victim_vld,
    output logic [IDX_W-1:0] victim_idx
);
    out_state_e           state_q, state_d;
    logic [N_ENTRIES-1:0] mask_q, mask_u, mask_d;
    logic [IDX_W-1:0]     last_q, last_u;
    logic [IDX_W-1:0]     lru_idx, nlu_idx, pick_idx, victim_q;
    logic                 lru_found;
    policy_e              pol;

    assign pol = policy_e'(policy_sel);

    // use strobe is folded in first (R8)
    tlbv_mark #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) i_mark_use (
        .mask_i(mask_q), .set_i(use_vld), .idx_i(use_idx), .mask_o(mask_u)
    );

    assign last_u = use_vld ? use_idx : last_q;

    tlbv_first_clear #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) i_first_clear (
        .mask_i(mask_u), .idx_o(lru_idx), .found_o(lru_found)
    );

    tlbv_rotor #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) i_rotor (
        .clk(clk), .rst_n(rst_n), .adv_i(alloc_req), .last_i(last_u), .cand_o(nlu_idx)
    );

    always_comb begin
        unique case (pol)
            POL_LRU: pick_idx = lru_idx;
            POL_NLU: pick_idx = nlu_idx;
            default: pick_idx = lru_idx;
        endcase
    end

    // allocation then marks the victim (R7)
    tlbv_mark #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) i_mark_alloc (
        .mask_i(mask_u), .set_i(alloc_req), .idx_i(pick_idx), .mask_o(mask_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            last_q   <= '0;
            victim_q <= '0;
        end else begin
            mask_q <= mask_d;
            last_q <= alloc_req ? pick_idx : last_u;
            if (alloc_req) victim_q <= pick_idx;
        end
    end

    // output state machine
    always_comb begin
        unique case (state_q)
            OUT_IDLE:    state_d = alloc_req ? OUT_PRESENT : OUT_IDLE;
            OUT_PRESENT: state_d = alloc_req ? OUT_PRESENT : OUT_IDLE;
            default:     state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        victim_vld = (state_q == OUT_PRESENT);
        victim_idx = victim_q;
    end

    // checker-side captures of what the allocation saw
    logic [N_ENTRIES-1:0] chk_mask_q;
    logic [IDX_W-1:0]     chk_last_q;
    policy_e              chk_pol_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_mask_q <= '0;
            chk_last_q <= '0;
            chk_pol_q  <= POL_LRU;
        end else if (alloc_req) begin
            chk_mask_q <= mask_u;
            chk_last_q <= last_u;
            chk_pol_q  <= pol;
        end
    end

    p_vld_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |=> victim_vld);

    p_vld_only_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_req |=> !victim_vld);

    p_lru_clear_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_vld && chk_pol_q == POL_LRU) |-> !chk_mask_q[victim_idx]);

    p_mask_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(&mask_q) && lru_found);

    p_nlu_not_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_vld && chk_pol_q == POL_NLU) |-> victim_idx != chk_last_q);

    p_alloc_marked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        victim_vld |-> (mask_q[victim_idx] && last_q == victim_idx));

    always_comb begin
        if (!rst_n) p_reset_idle_r9: assert (!victim_vld);
    end
endmodule

// File: tb/test_tlb_victim_sel.sv
`timescale 1ns/1ps
module test_tlb_victim_sel;
    localparam int N  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          use_vld = 1'b0;
    logic [IW-1:0] use_idx = '0;
    logic          alloc_req = 1'b0;
    logic          policy_sel = 1'b0;
    logic          victim_vld;
    logic [IW-1:0] victim_idx;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tlb_victim_sel #(.N_ENTRIES(N), .IDX_W(IW)) i_tlb_victim_sel (
        .clk(clk), .rst_n(rst_n), .use_vld(use_vld), .use_idx(use_idx),
        .alloc_req(alloc_req), .policy_sel(policy_sel),
        .victim_vld(victim_vld), .victim_idx(victim_idx)
    );

    // row layout: {use_vld, use_idx[1:0], alloc, policy, exp_vld, exp_idx[1:0]}
    localparam int ROWS = 17;
    localparam logic [7:0] VEC [ROWS] = '{
        8'b0_00_1_0_1_00,  // 1  LRU: 0
        8'b0_00_1_0_1_01,  // 2  LRU: 1
        8'b0_00_1_0_1_10,  // 3  LRU: 2
        8'b0_00_1_0_1_11,  // 4  LRU: 3, mask fold
        8'b0_00_1_0_1_00,  // 5  LRU after fold: 0
        8'b1_10_0_0_0_00,  // 6  use 2 only
        8'b0_00_1_0_1_01,  // 7  LRU: 1, fold
        8'b0_00_1_1_1_00,  // 8  NLU: 0
        8'b0_00_1_1_1_01,  // 9  NLU: 1
        8'b1_10_1_1_1_11,  // 10 use 2 + NLU: skip 2 -> 3
        8'b1_00_1_0_1_01,  // 11 use 0 + LRU: 1
        8'b0_00_1_1_1_10,  // 12 NLU: 2
        8'b0_00_1_1_1_11,  // 13 NLU: 3, pointer wraps
        8'b0_00_1_1_1_00,  // 14 NLU: 0
        8'b1_01_1_1_1_10,  // 15 use 1 (fold) + NLU: skip 1 -> 2
        8'b0_00_1_0_1_00,  // 16 LRU: 0
        8'b0_00_0_0_0_00   // 17 idle
    };

    task automatic check(input string tag, input logic [IW:0] act, input logic [IW:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: vld/idx actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic uv, input logic [IW-1:0] ui, input logic al, input logic pol);
        @(negedge clk);
        use_vld = uv; use_idx = ui; alloc_req = al; policy_sel = pol;
        @(negedge clk);
        use_vld = 1'b0; alloc_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; use_vld = 1'b0; alloc_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 reset vld", {victim_vld, IW'(0)}, {1'b0, IW'(0)});
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        for (int r = 0; r < ROWS; r++) begin
            logic [7:0] v;
            string tag;
            v = VEC[r];
            if (!v[2])                   tag = "R2";
            else if (v[7])               tag = "R8";
            else if (r == 3 || r == 6)   tag = "R4";
            else if (r == 12)            tag = "R6";
            else if (v[3])               tag = "R5";
            else                         tag = "R3";
            drive(v[7], v[6:5], v[4], v[3]);
            if (v[2]) check(tag, {victim_vld, victim_idx}, {1'b1, v[1:0]});
            else      check(tag, {victim_vld, IW'(0)}, {1'b0, IW'(0)});
        end

        // R9 then R7 then R1
        do_reset();
        drive(1'b0, '0, 1'b1, 1'b0);
        check("R9 first LRU after reset", {victim_vld, victim_idx}, {1'b1, 2'd0});
        drive(1'b0, '0, 1'b1, 1'b0);
        check("R7 allocated entry marked used", {victim_vld, victim_idx}, {1'b1, 2'd1});
        drive(1'b0, '0, 1'b1, 1'b1);
        check("R1 policy 1 takes pointer", {victim_vld, victim_idx}, {1'b1, 2'd3});

        // R6 wrap-skip: pointer at 3 collides with last-used 3
        do_reset();
        drive(1'b0, '0, 1'b1, 1'b1);
        check("R9 NLU after reset skips 0", {victim_vld, victim_idx}, {1'b1, 2'd1});
        drive(1'b1, 2'd3, 1'b1, 1'b1);
        check("R8 use 3 with NLU", {victim_vld, victim_idx}, {1'b1, 2'd2});
        drive(1'b1, 2'd3, 1'b1, 1'b1);
        check("R6 skip at wrap", {victim_vld, victim_idx}, {1'b1, 2'd0});
        drive(1'b0, '0, 1'b0, 1'b0);
        check("R2 no request no valid", {victim_vld, IW'(0)}, {1'b0, IW'(0)});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule